// File: doc/BRIEF.md
# Auto-Scan Channel Sequencer with Serial Control

This block is the digital control core of a sixteen-input sampling converter. A host talks to it in 16-bit serial frames: while the active-low frame select `frame_ni` is low, one command bit is taken from `sdi_i`, MSB first, on every rising edge of `clk_i`, which serves as the bit clock. The same edge count drives one bit of the reply word onto `sdo_o`. A command is acted on only when its sixteenth bit has arrived. Its upper nibble chooses the operating mode. The lower bits carry the sample range flag, the power-down request, the reply header choice and the general-purpose output data. A write-enable bit decides whether those lower settings are loaded or kept.

In scanning mode the block walks a channel pointer upward through the channels enabled in a 16-bit mask and wraps from the highest to the lowest. The pointer drives the input multiplexer select. The converter result for the selected channel arrives on `adc_data_i`. It is latched at the end of a frame and shifted out during the following frame, so a channel's data leaves two frames after the command that pointed the multiplexer at it. The mask is loaded by a two-frame sequence: an arming command, then a frame that is taken whole as the mask. The analog front end lies outside the block.

Top module: `scan_seq`

## Requirements
- R1: After reset `mode_o` is 0001, `mux_sel_o`, `gpio_o`, `pwr_down_o` and `range_x2_o` are 0 and `sdo_o` is 0. A frame is 16 bits captured MSB first on rising edges with `frame_ni` low. It takes effect on the edge that captures its sixteenth bit, and its bits [15:12] become `mode_o` (except for the arming code 1000).
- R2: If `frame_ni` rises before sixteen bits have been captured, the frame is discarded: no setting, mode, mask or pointer changes, and the next frame starts counting from bit 0.
- R3: A frame with mode 0010 received while the mode is anything else enters scanning and sets `mux_sel_o` to the lowest enabled channel at that frame's completion.
- R4: Each further completed 0010 frame in scanning mode moves `mux_sel_o` to the next higher enabled channel, wrapping from the highest enabled channel to the lowest.
- R5: During a frame, `sdo_o` shifts out, MSB first, the word latched at the previous completion: bits [11:0] are `adc_data_i` as it stood then (the result of the channel then selected), and bits [15:12] are the header. `sdo_o` is 0 while `frame_ni` is high.
- R6: With bit 11 of a command at 0, bits [10:0] are ignored and the range, power-down, header and GPIO settings keep their values; with bit 11 at 1 they are loaded.
- R7: A 0010 frame with bits 11 and 10 both at 1 sends `mux_sel_o` back to the lowest enabled channel; with bit 10 at 0 the scan keeps advancing.
- R8: A loaded bit 6 drives `range_x2_o` and a loaded bit 5 drives `pwr_down_o`; both change only on the completion edge of the frame.
- R9: Header select (bit 11 write, bit 4 value) in force while a frame completes chooses the latched header: 0 gives the selected channel number, 1 gives the four GPIO pin levels, pin 3 in bit 15 down to pin 0 in bit 12, where a pin's level is `gpio_o` for an output pin and `gpio_in_i` for an input pin.
- R10: Bits [3:0] of a loaded command go to `gpio_o[3:0]` only for pins whose `gpio_dir_i` bit is 1 (output); an input pin's `gpio_o` bit keeps its value.
- R11: A frame with mode 1000 arms a mask load and leaves the mode unchanged; the next complete frame is stored whole as the channel mask, bit c enabling channel c.
- R12: A mask load completed while scanning moves `mux_sel_o` from its current channel to the next higher enabled channel of the new mask (with wrap), not to the lowest.
- R13: With an all-zero mask, and in any mode other than scanning, `mux_sel_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock and block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Frame select, active low |
| sdi_i | input | 1 | Serial command data |
| sdo_o | output | 1 | Serial reply data |
| adc_data_i | input | 12 | Conversion result of the selected channel |
| gpio_dir_i | input | 4 | Pin direction, 1 = output |
| gpio_in_i | input | 4 | Pin levels of input pins |
| gpio_o | output | 4 | Output latches of GPIO pins |
| mux_sel_o | output | 4 | Input multiplexer channel select |
| mode_o | output | 4 | Current mode code |
| range_x2_o | output | 1 | Double input range flag |
| pwr_down_o | output | 1 | Power-down request |

## Verification
The scan is driven with two masks of different shape, a sparse three-channel mask and one spanning channel 0 and the top of the range. The runs step past the wrap point, so ascending order, wrap and restart-on-entry show up as distinct select sequences. Each frame's reply is compared to the result latched two frames earlier, which separates a one-frame from a two-frame pipeline. A mask rewrite during a scan must land on the next channel of the new mask rather than its lowest. Counter-restart against continue, a short frame against a full one, and loaded against retained settings are each run as paired frames that differ in that one bit or length.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int unsigned FRAME_W   = 16;
  localparam int unsigned HDR_W     = 4;
  localparam int unsigned GPIO_W    = 4;
  localparam int unsigned MODE_HI   = 15;
  localparam int unsigned MODE_LO   = 12;
  localparam int unsigned BIT_PROG  = 11;
  localparam int unsigned BIT_CRST  = 10;
  localparam int unsigned BIT_RANGE = 6;
  localparam int unsigned BIT_PD    = 5;
  localparam int unsigned BIT_HSEL  = 4;

  localparam logic [3:0] MODE_HOLD = 4'b0001;
  localparam logic [3:0] MODE_AUTO = 4'b0010;
  localparam logic [3:0] MODE_ARM  = 4'b1000;
endpackage

// File: rtl/serial_rx.sv
module serial_rx #(
  parameter int unsigned FRAME_W = 16,
  localparam int unsigned CNT_W  = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_ni,
  input  logic               sdi_i,
  input  logic [FRAME_W-1:0] tx_word_i,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic               done_o,
  output logic               sdo_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-2:0] shift_q;
  logic [CNT_W-1:0]   tx_idx;

  assign done_o    = !frame_ni && (cnt_q == CNT_W'(FRAME_W - 1));
  assign rx_word_o = {shift_q, sdi_i};
  assign tx_idx    = CNT_W'(FRAME_W - 1) - cnt_q;
  assign sdo_o     = frame_ni ? 1'b0 : tx_word_i[tx_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (frame_ni) begin
      cnt_q <= '0;  // short frame dropped
    end else begin
      shift_q <= {shift_q[FRAME_W-3:0], sdi_i};
      cnt_q   <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/chan_seek.sv
module chan_seek #(
  parameter int unsigned N_CH = 16,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] mask_i,
  input  logic [CH_W-1:0] cur_i,
  output logic [CH_W-1:0] first_o,
  output logic [CH_W-1:0] next_o
);
  always_comb begin
    first_o = cur_i;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (mask_i[i]) first_o = CH_W'(i);
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    next_o = cur_i;
    for (int k = 1; k <= N_CH; k++) begin
      int j;
      j = (int'(cur_i) + k) % N_CH;
      if (!found && mask_i[j]) begin
        next_o = CH_W'(j);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int unsigned N_CH   = 16,
  parameter int unsigned DATA_W = 12,
  localparam int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic [FRAME_W-1:0] rx_word_i,
  input  logic [DATA_W-1:0]  adc_data_i,
  input  logic [GPIO_W-1:0]  gpio_dir_i,
  input  logic [GPIO_W-1:0]  gpio_in_i,
  output logic [FRAME_W-1:0] tx_word_o,
  output logic [CH_W-1:0]    mux_sel_o,
  output logic [N_CH-1:0]    mask_o,
  output logic [3:0]         mode_o,
  output logic               range_o,
  output logic               pd_o,
  output logic [GPIO_W-1:0]  gpio_o
);
  logic [3:0]         mode_q;
  logic               armed_q;
  logic [N_CH-1:0]    mask_q;
  logic [CH_W-1:0]    ptr_q, ptr_d;
  logic               range_q, pd_q, hsel_q;
  logic [GPIO_W-1:0]  gpio_q, pin_lvl;
  logic [FRAME_W-1:0] tx_q;
  logic [HDR_W-1:0]   hdr;

  logic [3:0]      cmd_mode;
  logic            is_arm, mask_wr, cmd_wr, load;
  logic [N_CH-1:0] seek_mask;
  logic [CH_W-1:0] first_ch, next_ch;

  assign cmd_mode  = rx_word_i[MODE_HI:MODE_LO];
  assign mask_wr   = armed_q;
  assign is_arm    = !armed_q && (cmd_mode == MODE_ARM);
  assign cmd_wr    = !armed_q && !is_arm;
  assign load      = cmd_wr && rx_word_i[BIT_PROG];
  assign seek_mask = mask_wr ? rx_word_i[N_CH-1:0] : mask_q;

  chan_seek #(.N_CH(N_CH)) u_seek (
    .mask_i  (seek_mask),
    .cur_i   (ptr_q),
    .first_o (first_ch),
    .next_o  (next_ch)
  );

  always_comb begin
    ptr_d = ptr_q;
    if (mask_wr) begin
      if (mode_q == MODE_AUTO) ptr_d = next_ch;
    end else if (cmd_wr && cmd_mode == MODE_AUTO) begin
      if (mode_q != MODE_AUTO || (load && rx_word_i[BIT_CRST])) ptr_d = first_ch;
      else                                                       ptr_d = next_ch;
    end
  end

  for (genvar g = 0; g < GPIO_W; g++) begin : g_pin
    assign pin_lvl[g] = gpio_dir_i[g] ? gpio_q[g] : gpio_in_i[g];
  end

  assign hdr = hsel_q ? HDR_W'(pin_lvl) : HDR_W'(ptr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_HOLD;
      armed_q <= 1'b0;
      mask_q  <= '0;
      ptr_q   <= '0;
      range_q <= 1'b0;
      pd_q    <= 1'b0;
      hsel_q  <= 1'b0;
      gpio_q  <= '0;
      tx_q    <= '0;
    end else if (done_i) begin
      armed_q <= is_arm;
      ptr_q   <= ptr_d;
      tx_q    <= {hdr, adc_data_i};
      if (mask_wr) mask_q <= rx_word_i[N_CH-1:0];
      if (cmd_wr)  mode_q <= cmd_mode;
      if (load) begin
        range_q <= rx_word_i[BIT_RANGE];
        pd_q    <= rx_word_i[BIT_PD];
        hsel_q  <= rx_word_i[BIT_HSEL];
        gpio_q  <= (gpio_q & ~gpio_dir_i) | (rx_word_i[GPIO_W-1:0] & gpio_dir_i);
      end
    end
  end

  assign tx_word_o = tx_q;
  assign mux_sel_o = ptr_q;
  assign mask_o    = mask_q;
  assign mode_o    = mode_q;
  assign range_o   = range_q;
  assign pd_o      = pd_q;
  assign gpio_o    = gpio_q;
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter int unsigned N_CH   = 16,
  parameter int unsigned DATA_W = 12,
  localparam int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [DATA_W-1:0] adc_data_i,
  input  logic [GPIO_W-1:0] gpio_dir_i,
  input  logic [GPIO_W-1:0] gpio_in_i,
  output logic [GPIO_W-1:0] gpio_o,
  output logic [CH_W-1:0]   mux_sel_o,
  output logic [3:0]        mode_o,
  output logic              range_x2_o,
  output logic              pwr_down_o
);
  logic               frame_done;
  logic [FRAME_W-1:0] rx_word, tx_word;
  logic [N_CH-1:0]    chan_mask;

  serial_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_ni  (frame_ni),
    .sdi_i     (sdi_i),
    .tx_word_i (tx_word),
    .rx_word_o (rx_word),
    .done_o    (frame_done),
    .sdo_o     (sdo_o)
  );

  scan_ctrl #(.N_CH(N_CH), .DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (frame_done),
    .rx_word_i  (rx_word),
    .adc_data_i (adc_data_i),
    .gpio_dir_i (gpio_dir_i),
    .gpio_in_i  (gpio_in_i),
    .tx_word_o  (tx_word),
    .mux_sel_o  (mux_sel_o),
    .mask_o     (chan_mask),
    .mode_o     (mode_o),
    .range_o    (range_x2_o),
    .pd_o       (pwr_down_o),
    .gpio_o     (gpio_o)
  );
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int unsigned N_CH = 16,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frame_ni,
  input logic            done_i,
  input logic            sdo_i,
  input logic [CH_W-1:0] mux_sel_i,
  input logic [N_CH-1:0] mask_i,
  input logic            pwr_down_i,
  input logic [15:0]     tx_word_i,
  input logic [3:0]      gpio_i,
  input logic [3:0]      gpio_dir_i
);
  AST_MUX_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(mux_sel_i)); // R2
  AST_MUX_IN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mux_sel_i) |-> mask_i[mux_sel_i]); // R4
  AST_PD_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(pwr_down_i)); // R8
  AST_TX_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(tx_word_i)); // R5
  AST_SDO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ni |-> !sdo_i); // R5
  AST_GPIO_IN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((gpio_i ^ $past(gpio_i)) & ~$past(gpio_dir_i)) == 4'b0)); // R10
endmodule

bind scan_seq scan_seq_chk #(.N_CH(N_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_ni   (frame_ni),
  .done_i     (frame_done),
  .sdo_i      (sdo_o),
  .mux_sel_i  (mux_sel_o),
  .mask_i     (chan_mask),
  .pwr_down_i (pwr_down_o),
  .tx_word_i  (tx_word),
  .gpio_i     (gpio_o),
  .gpio_dir_i (gpio_dir_i)
);

// File: tb/scan_seq_tb.sv
`timescale 1ns/1ps
module scan_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_ni = 1'b1;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [11:0] adc_data;
  logic [3:0]  gpio_dir = 4'b0000;
  logic [3:0]  gpio_in = 4'b0000;
  logic [3:0]  gpio_out, mux_sel, mode;
  logic        range_x2, pwr_down;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [15:0] rx;

  always #2 clk = ~clk;

  // result of the selected channel: 0xC3 then channel number
  assign adc_data = {8'hC3, mux_sel};

  scan_seq u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .frame_ni   (frame_ni),
    .sdi_i      (sdi),
    .sdo_o      (sdo),
    .adc_data_i (adc_data),
    .gpio_dir_i (gpio_dir),
    .gpio_in_i  (gpio_in),
    .gpio_o     (gpio_out),
    .mux_sel_o  (mux_sel),
    .mode_o     (mode),
    .range_x2_o (range_x2),
    .pwr_down_o (pwr_down)
  );

  // {command, expected mux after frame, expected sdo word during frame}
  localparam int NVEC = 17;
  localparam logic [35:0] VEC [NVEC] = '{
    {16'h8000, 4'd0,  16'h0000},   // R11 arm
    {16'h0064, 4'd0,  16'h0C30},   // R11 mask ch2,5,6
    {16'h2000, 4'd2,  16'h0C30},   // R3 entry
    {16'h2000, 4'd5,  16'h0C30},   // R4
    {16'h2000, 4'd6,  16'h2C32},   // R4
    {16'h2000, 4'd2,  16'h5C35},   // R4 wrap
    {16'h2000, 4'd5,  16'h6C36},   // R5
    {16'h2C00, 4'd2,  16'h2C32},   // R7 restart
    {16'h2000, 4'd5,  16'h5C35},   // R7
    {16'h1000, 4'd5,  16'h2C32},   // R13 other mode holds
    {16'h2000, 4'd2,  16'h5C35},   // R3 re-entry restarts
    {16'h2000, 4'd5,  16'h5C35},   // R4
    {16'h8000, 4'd5,  16'h2C32},   // R11 arm in scan
    {16'h0A01, 4'd9,  16'h5C35},   // R12 rewrite -> next in new mask
    {16'h2000, 4'd11, 16'h5C35},   // R12
    {16'h2000, 4'd0,  16'h9C39},   // R4 wrap
    {16'h2000, 4'd9,  16'hBC3B}    // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nbits, output logic [15:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      frame_ni = 1'b0;
      sdi = w[15-i];
      #1 got[15-i] = sdo;
    end
    @(negedge clk);
    frame_ni = 1'b1;
    sdi = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", 32'(mode), 32'h1);
    chk("R1 mux", 32'(mux_sel), 32'h0);
    chk("R1 gpio", 32'(gpio_out), 32'h0);
    chk("R1 pd", 32'(pwr_down), 32'h0);
    chk("R1 range", 32'(range_x2), 32'h0);
    chk("R1 sdo idle", 32'(sdo), 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][35:20], 16, rx);
      chk($sformatf("R4 vec%0d mux", v), 32'(mux_sel), 32'(VEC[v][19:16]));
      chk($sformatf("R5 vec%0d sdo", v), 32'(rx), 32'(VEC[v][15:0]));
    end
    chk("R3 mode auto", 32'(mode), 32'h2);

    // R2 short frame discarded
    send(16'h1000, 10, rx);
    chk("R2 short mode", 32'(mode), 32'h2);
    chk("R2 short mux", 32'(mux_sel), 32'd9);
    send(16'h2000, 16, rx);
    chk("R2 full after short", 32'(mux_sel), 32'd11);

    // R6 R8 R9 R10
    gpio_dir = 4'b0101;
    gpio_in  = 4'b0000;
    send(16'h285F, 16, rx);
    chk("R4 mux", 32'(mux_sel), 32'd0);
    chk("R8 range", 32'(range_x2), 32'h1);
    chk("R8 pd", 32'(pwr_down), 32'h0);
    chk("R10 gpio dir mask", 32'(gpio_out), 32'h5);
    send(16'h2000, 16, rx);
    chk("R6 range kept", 32'(range_x2), 32'h1);
    chk("R6 gpio kept", 32'(gpio_out), 32'h5);
    chk("R9 addr header", 32'(rx), 32'hBC3B);
    chk("R4 mux", 32'(mux_sel), 32'd9);
    send(16'h2000, 16, rx);
    chk("R9 gpio header", 32'(rx), 32'h5C30);
    chk("R4 mux", 32'(mux_sel), 32'd11);

    // R7 restart vs continue, R8 power-down
    send(16'h2C20, 16, rx);
    chk("R7 restart", 32'(mux_sel), 32'd0);
    chk("R8 pd set", 32'(pwr_down), 32'h1);
    chk("R8 range clr", 32'(range_x2), 32'h0);
    chk("R10 gpio clr", 32'(gpio_out), 32'h0);
    send(16'h2800, 16, rx);
    chk("R7 continue", 32'(mux_sel), 32'd9);
    chk("R8 pd clr", 32'(pwr_down), 32'h0);

    // R13 empty mask and non-scan hold
    send(16'h8000, 16, rx);
    send(16'h0000, 16, rx);
    chk("R13 empty rewrite", 32'(mux_sel), 32'd9);
    send(16'h2000, 16, rx);
    chk("R13 empty step", 32'(mux_sel), 32'd9);
    send(16'h1000, 16, rx);
    chk("R1 mode hold", 32'(mode), 32'h1);
    chk("R13 hold mode", 32'(mux_sel), 32'd9);
    send(16'h2000, 16, rx);
    chk("R13 empty entry", 32'(mux_sel), 32'd9);
    chk("R3 mode", 32'(mode), 32'h2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule